// File: doc/BRIEF.md
# Single-Bit Quadrature Down-Mixer

This block takes a one-bit oversampled stream from a delta or delta-sigma modulator and shifts it down to baseband. It multiplies the stream by two one-bit square-wave local oscillators that sit a quarter period apart. The result is two one-bit product streams, one in-phase and one quadrature, which the decimation filters that follow turn into multi-bit words.

The oscillators are not stored as a table. A reference that runs at four times the oscillator rate drives a short chain of toggle stages, and the oscillators are decoded from that chain. Here the reference is the sample strobe itself, so each oscillator completes one period every four accepted samples. Because a data bit and an oscillator level both mean +1 or −1, each product is the XNOR of the two.

A two-bit phase offset input rotates the starting point of both oscillators together, and the I/Q offset stays the same. Both oscillator levels are brought out so their alignment can be observed.

Top module: `qmix_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the toggle chain clears. After that edge, with `phase_ofs` = 0, `lo_i` = 1, `lo_q` = 0, `prod_valid` = 0, `i_bit` = 0 and `q_bit` = 0.
- R2: With `phase_ofs` = 0, the oscillator levels shown during the k-th accepted sample after reset (k = 0, 1, 2, …) repeat with period 4. `lo_i` is 1,1,0,0 and `lo_q` is 0,1,1,0.
- R3: After each accepted sample with an unchanged `phase_ofs`, `lo_q` equals the `lo_i` value shown during that sample. This is a lag of exactly one quarter period.
- R4: The toggle chain advances only on a clock edge where `smp_valid` is 1. Cycles with `smp_valid` = 0 leave `lo_i` and `lo_q` unchanged.
- R5: On an edge where `smp_valid` is 1, `i_bit` becomes 1 when `smp_bit` equals `lo_i` and 0 otherwise. `q_bit` is formed the same way from `lo_q`. Both use the levels shown during that cycle and appear one cycle later.
- R6: `prod_valid` is `smp_valid` delayed by one cycle. When `smp_valid` is 0, `i_bit` and `q_bit` hold their previous values.
- R7: The phase index is (accepted-sample count + `phase_ofs`) mod 4. `lo_i` is 1 for index 0 or 1, and `lo_q` is 1 for index 1 or 2.
- R8: A reset in the middle of a stream returns the oscillators to index `phase_ofs`, that is, to a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Strobe marking an accepted sample |
| smp_bit | input | 1 | One-bit modulator output (1 = +1, 0 = −1) |
| phase_ofs | input | 2 | Rotation applied to both oscillators |
| i_bit | output | 1 | Registered in-phase product |
| q_bit | output | 1 | Registered quadrature product |
| prod_valid | output | 1 | Strobe marking valid products |
| lo_i | output | 1 | In-phase oscillator level for the current sample |
| lo_q | output | 1 | Quadrature oscillator level for the current sample |

## Verification
The embedded assertions check several rules on every cycle. They check the quarter-period lag of `lo_q` behind `lo_i`, that the chain holds through idle cycles, and that the strobe passes through with a one-cycle delay. They also check that products hold while idle and that each product matches the XNOR of the previous cycle's data and oscillator level. Other behaviour can only be shown by the directed scenarios. These cover the absolute phase of the 1,1,0,0 / 0,1,1,0 pattern after reset, the effect of each `phase_ofs` value, and the restart after a reset mid-stream. They also cover the product streams under constant, alternating and gapped data.

// File: rtl/qmix_pkg.sv
// Package: shared sizing and channel indices for the quadrature mixer.
// Assumes a four-phase oscillator, i.e. a two-stage toggle chain.
package qmix_pkg;
    localparam int PHASE_W = 2;             // toggle stages in the divider
    localparam int NUM_CH  = 2;             // in-phase and quadrature
    localparam int CH_I    = 0;
    localparam int CH_Q    = 1;
endpackage

// File: rtl/qmix_lo_div.sv
// Module: toggle-stage divider producing the I and Q square waves.
// Each stage toggles when the sample strobe is high and all lower stages
// are 1, giving a synchronous binary count. The oscillators are decoded
// from that count after adding a phase rotation.
// Assumes PHASE_W >= 2; reset is synchronous, active low.
module qmix_lo_div #(
    parameter int PHASE_W = qmix_pkg::PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic [PHASE_W-1:0] phase_ofs_i,
    output logic               lo_i_o,
    output logic               lo_q_o
);
    logic [PHASE_W-1:0] tq;
    logic [PHASE_W:0]   carry;
    logic [PHASE_W-1:0] idx;

    assign carry[0] = adv_i;

    for (genvar j = 0; j < PHASE_W; j++) begin : g_stage
        // Carry into the next stage: this stage is at 1 and is toggling.
        assign carry[j+1] = carry[j] & tq[j];

        // Toggle stage j when its carry input is high.
        always_ff @(posedge clk) begin
            if (!rst_n)        tq[j] <= 1'b0;
            else if (carry[j]) tq[j] <= ~tq[j];
        end
    end

    // Rotate the count, then decode the top two bits into I and Q levels.
    always_comb begin
        idx    = tq + phase_ofs_i;
        lo_i_o = ~idx[PHASE_W-1];
        lo_q_o = idx[PHASE_W-1] ^ idx[PHASE_W-2];
    end

    // R3
    quarter_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (phase_ofs_i != $past(phase_ofs_i)) || (lo_q_o == $past(lo_i_o)));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(tq));
endmodule

// File: rtl/qmix_prod.sv
// Module: registered sign multipliers, one per oscillator channel.
// Encoding: 1 means +1 and 0 means -1, so the product is an XNOR.
// The strobe is forwarded with the same one-cycle delay.
// Assumes synchronous active-low reset.
module qmix_prod #(
    parameter int NUM_CH = qmix_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              data_i,
    input  logic [NUM_CH-1:0] lo_i,
    output logic [NUM_CH-1:0] prod_o,
    output logic              valid_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Capture the sign product of data and oscillator on a valid sample.
        always_ff @(posedge clk) begin
            if (!rst_n)       prod_o[c] <= 1'b0;
            else if (valid_i) prod_o[c] <= ~(data_i ^ lo_i[c]);
        end
    end

    // Delay the sample strobe to line up with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // R6
    strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o && $stable(prod_o));
endmodule

// File: rtl/qmix_top.sv
// Module: single-bit quadrature down-mixer top.
// The divider is clocked by the sample strobe (4x the oscillator rate),
// and the oscillator levels feed the registered product stage.
// Assumes one-bit input data and synchronous active-low reset.
module qmix_top (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       smp_bit,
    input  logic [1:0] phase_ofs,
    output logic       i_bit,
    output logic       q_bit,
    output logic       prod_valid,
    output logic       lo_i,
    output logic       lo_q
);
    import qmix_pkg::*;

    logic [NUM_CH-1:0] lo_vec;
    logic [NUM_CH-1:0] prod_vec;

    qmix_lo_div #(.PHASE_W(PHASE_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (smp_valid),
        .phase_ofs_i(phase_ofs),
        .lo_i_o     (lo_i),
        .lo_q_o     (lo_q)
    );

    assign lo_vec[CH_I] = lo_i;
    assign lo_vec[CH_Q] = lo_q;

    qmix_prod #(.NUM_CH(NUM_CH)) prod_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(smp_valid),
        .data_i (smp_bit),
        .lo_i   (lo_vec),
        .prod_o (prod_vec),
        .valid_o(prod_valid)
    );

    assign i_bit = prod_vec[CH_I];
    assign q_bit = prod_vec[CH_Q];

    // R5
    i_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> i_bit == ($past(smp_bit) == $past(lo_i)));

    // R5
    q_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> q_bit == ($past(smp_bit) == $past(lo_q)));
endmodule

// File: tb/qmix_top_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a phase-count model kept in the bench.
module qmix_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic       smp_bit = 1'b0;
    logic [1:0] phase_ofs = 2'd0;
    logic       i_bit, q_bit, prod_valid, lo_i, lo_q;

    int n_chk = 0;
    int n_bad = 0;
    int cnt   = 0;       // accepted samples since reset, mod 4
    logic pi = 1'b0, pq = 1'b0;   // last expected products

    always #2 clk = ~clk;  // 250 MHz

    qmix_top dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_i(input int k);
        return ((k % 4) < 2);
    endfunction
    function automatic logic exp_q(input int k);
        return ((k % 4) == 1) || ((k % 4) == 2);
    endfunction

    // One cycle: drive at negedge, check LO levels, check results next negedge.
    task automatic step(input logic v, input logic d, input string req);
        int k;
        logic ei, eq;
        smp_valid = v;
        smp_bit   = d;
        #0;
        k  = cnt + int'(phase_ofs);
        ei = exp_i(k);
        eq = exp_q(k);
        chk(lo_i == ei, {req, " lo_i"}, lo_i, ei);
        chk(lo_q == eq, {req, " lo_q"}, lo_q, eq);
        if (v) begin
            pi = (d == ei);
            pq = (d == eq);
        end
        @(posedge clk);
        @(negedge clk);
        if (v) cnt = (cnt + 1) % 4;
        chk(prod_valid == v, {req, " R6 prod_valid"}, prod_valid, v);
        chk(i_bit == pi, {req, " R5 i_bit"}, i_bit, pi);
        chk(q_bit == pq, {req, " R5 q_bit"}, q_bit, pq);
    endtask

    task automatic do_reset();
        smp_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        pi = 1'b0;
        pq = 1'b0;
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        phase_ofs = 2'd0;
        do_reset();
        chk(lo_i == 1'b1, "R1 lo_i", lo_i, 1);
        chk(lo_q == 1'b0, "R1 lo_q", lo_q, 0);
        chk(prod_valid == 1'b0, "R1 prod_valid", prod_valid, 0);
        chk(i_bit == 1'b0 && q_bit == 1'b0, "R1 products", {i_bit, q_bit}, 0);
    endtask

    // R2/R3: oscillator pattern over two periods, all-ones data.
    task automatic t_sequence();
        logic prev_i;
        for (int s = 0; s < 8; s++) begin
            prev_i = lo_i;
            step(1'b1, 1'b1, "R2");
            if (s < 7) chk(lo_q == prev_i, "R3 quarter lag", lo_q, prev_i);
        end
    endtask

    // R5: alternating and zero data patterns.
    task automatic t_products();
        for (int s = 0; s < 8; s++) step(1'b1, logic'(s % 2), "R5 alt");
        for (int s = 0; s < 5; s++) step(1'b1, 1'b0, "R5 zeros");
        for (int s = 0; s < 6; s++) step(1'b1, logic'((s / 3) % 2), "R5 blocks");
    endtask

    // R4/R6: idle gaps hold the oscillators and the products.
    task automatic t_gaps();
        for (int s = 0; s < 12; s++)
            step(logic'((s % 3) == 0), logic'(s % 2), "R4 gaps");
        step(1'b0, 1'b1, "R4 idle");
        step(1'b0, 1'b0, "R4 idle");
    endtask

    // R7: each rotation value, fresh from reset.
    task automatic t_offset();
        for (int o = 0; o < 4; o++) begin
            phase_ofs = 2'(o);
            do_reset();
            for (int s = 0; s < 5; s++) step(1'b1, logic'((s + o) % 2), "R7 offset");
        end
        phase_ofs = 2'd0;
    endtask

    // R8: reset mid-stream returns to count zero.
    task automatic t_midreset();
        phase_ofs = 2'd0;
        do_reset();
        for (int s = 0; s < 3; s++) step(1'b1, 1'b1, "R8 pre");
        do_reset();
        chk(lo_i == 1'b1, "R8 lo_i", lo_i, 1);
        chk(lo_q == 1'b0, "R8 lo_q", lo_q, 0);
        for (int s = 0; s < 4; s++) step(1'b1, 1'b0, "R8 post");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequence();
        t_products();
        t_gaps();
        t_offset();
        t_midreset();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule